// File: doc/BRIEF.md
# CPU Clock Level Transition Sequencer

This block moves a processor clock from one operating level to another without software stepping through the registers. A request carries a target level index. The block holds a per-level table of two clock-divider words and a PLL setting (multiplier M, pre-divider P, post-divider S). From that table it issues single-cycle write strobes, with data, to the divider block, the PLL control register, the PLL lock-time register and the core clock mux. After each write it waits on the matching status input before it moves on.

The order of the steps depends on the direction of the change. When the frequency rises, the dividers change first. When it falls, the PLL changes first. A full PLL change parks the core clock on an alternate source while the PLL relocks. When M and P are the same at both levels, only S is rewritten and no relock takes place. Every wait is bounded by a programmable timeout. A timeout sets a sticky error flag and abandons the change. The current level only moves on a successful completion.

Top module: `dvfs_seq`

## Requirements
- R1: There are 14 levels; index 0 is 1500 MHz and each higher index is 100 MHz lower, down to 200 MHz at index 13. After reset `cur_level` is 7 (800 MHz). `safe_level` is the constant 7.
- R2: When the target index is below the current index (frequency rises), both divider writes come before any PLL, lock-time or mux write.
- R3: When the target index is above the current index (frequency falls), every PLL, lock-time and mux write comes before the divider writes.
- R4: When M and P of the two levels are equal, the PLL side is exactly one `pll_we` write: `pll_rd` with bits [2:0] replaced by the target S. There is no mux or lock-time write.
- R5: A full PLL change writes the mux with `mux_to_alt`=1 and waits for `mux_stat`==2. It then writes `lock_wd` = P×250, writes the PLL word, and waits for `pll_locked`=1. Last, it writes the mux with `mux_to_alt`=0 and waits for `mux_stat`==1.
- R6: A full PLL word places M in [25:16], P in [13:8] and S in [2:0], and keeps every other bit of `pll_rd`. Per level (M/P/S): 0:250/4/0, 1:175/3/0, 2:325/6/0, 3:200/4/0, 4:275/6/0, 5:125/3/0, 6:150/4/0, 7:100/3/0, 8:175/3/1, 9:200/4/1, 10:125/3/1, 11:100/3/1, 12:200/4/2, 13:100/3/2.
- R7: The divider step writes `div0_wd` and waits until `div0_stat & 32'h11111111` is zero. It then writes `div1_wd` and waits until `div1_stat` under the variant mask is zero. The `div0_wd` hex words per level are: 0,1:02160730; 2,3:02150730; 4:02140630; 5:01140520; 6,7:01130520; 8-11:01130420; 12:01120420; 13:01110310.
- R8: A request for the current level gives `ack` on the next cycle. It makes no write, and `busy` stays low.
- R9: `busy` is high from the cycle after acceptance until completion. `ack` is a one-cycle pulse with `busy` low. A request while busy is ignored. A request with `req_level` above 13 is ignored: no ack and no write.
- R10: Each wait counts cycles from 0. If the condition is still false in the cycle whose count equals `tmo_limit`, `err` is set and the block returns to idle with no `ack` and `cur_level` unchanged. A condition met in that same cycle wins. `err` stays set until reset.
- R11: `cur_level` changes only together with `ack`, and then takes the target index.
- R12: With `VARIANT`=0, `div1_wd` = {copy in [3:0], 2 in [7:4]} and its mask is 32'h11. With `VARIANT`=1, `div1_wd` = {copy in [3:0], 0 in [7:4], (14−level)/2 in [11:8]} and its mask is 32'h111. The copy value is 6 for levels 0-1, 5 for 2-3, 4 for 4-5 and 3 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tmo_limit | input | TMO_W | Last count at which each wait may still succeed |
| req | input | 1 | Transition request |
| req_level | input | 4 | Target level index |
| busy | output | 1 | Transition in progress |
| ack | output | 1 | One-cycle completion pulse |
| err | output | 1 | Sticky timeout flag |
| cur_level | output | 4 | Level now in force |
| safe_level | output | 4 | Constant fallback level (7) |
| div0_we | output | 1 | First divider word write strobe |
| div0_wd | output | 32 | First divider word |
| div0_stat | input | 32 | First divider status |
| div1_we | output | 1 | Second divider word write strobe |
| div1_wd | output | 32 | Second divider word |
| div1_stat | input | 32 | Second divider status |
| pll_we | output | 1 | PLL control write strobe |
| pll_wd | output | 32 | PLL control write data |
| pll_rd | input | 32 | Present PLL control word |
| pll_locked | input | 1 | PLL lock indication |
| lock_we | output | 1 | Lock-time write strobe |
| lock_wd | output | 16 | Lock-time value |
| mux_we | output | 1 | Core clock mux write strobe |
| mux_to_alt | output | 1 | 1 selects the alternate source, 0 the main PLL |
| mux_stat | input | 3 | Mux status: 2 alternate, 1 main |

## Verification
Two pairs of events can fall in the same cycle. The first is completion and a new request. The bench holds `req` high with a different target through the final status wait and drops it only when `ack` appears. It then expects no further writes and `busy` to stay low. The second is a wait condition and timeout expiry. The modelled status delay is fixed, so setting `tmo_limit` equal to it makes the condition arrive in the very cycle the count reaches the limit. That case must complete cleanly, while one less must raise `err` and keep `cur_level`.

// File: rtl/dvfs_seq.sv
module dvfs_seq #(
  parameter int VARIANT = 0,
  parameter int TMO_W   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TMO_W-1:0] tmo_limit,
  input  logic             req,
  input  logic [3:0]       req_level,
  output logic             busy,
  output logic             ack,
  output logic             err,
  output logic [3:0]       cur_level,
  output logic [3:0]       safe_level,
  output logic             div0_we,
  output logic [31:0]      div0_wd,
  input  logic [31:0]      div0_stat,
  output logic             div1_we,
  output logic [31:0]      div1_wd,
  input  logic [31:0]      div1_stat,
  output logic             pll_we,
  output logic [31:0]      pll_wd,
  input  logic [31:0]      pll_rd,
  input  logic             pll_locked,
  output logic             lock_we,
  output logic [15:0]      lock_wd,
  output logic             mux_we,
  output logic             mux_to_alt,
  input  logic [2:0]       mux_stat
);
  localparam int          LEVELS     = 14;
  localparam logic [3:0]  SAFE       = 4'd7;
  localparam logic [31:0] D0_MASK    = 32'h1111_1111;
  localparam logic [31:0] D1_MASK    = (VARIANT != 0) ? 32'h0000_0111 : 32'h0000_0011;
  localparam logic [31:0] PLL_FIELDS = 32'h03FF_3F07;

  typedef enum logic [3:0] {
    S_IDLE, S_D0W, S_D0P, S_D1W, S_D1P, S_SW,
    S_MAW, S_MAP, S_LKW, S_PW, S_PP, S_MMW, S_MMP
  } st_t;

  st_t              st, nxt;
  logic [3:0]       cur, tgt;
  logic             up, full, fin, is_wait, wait_ok, ack_q, err_q;
  logic [TMO_W-1:0] tcnt;

  function automatic logic [18:0] mps(input logic [3:0] l);
    case (l)
      4'd0:    mps = {10'd250, 6'd4, 3'd0};
      4'd1:    mps = {10'd175, 6'd3, 3'd0};
      4'd2:    mps = {10'd325, 6'd6, 3'd0};
      4'd3:    mps = {10'd200, 6'd4, 3'd0};
      4'd4:    mps = {10'd275, 6'd6, 3'd0};
      4'd5:    mps = {10'd125, 6'd3, 3'd0};
      4'd6:    mps = {10'd150, 6'd4, 3'd0};
      4'd7:    mps = {10'd100, 6'd3, 3'd0};
      4'd8:    mps = {10'd175, 6'd3, 3'd1};
      4'd9:    mps = {10'd200, 6'd4, 3'd1};
      4'd10:   mps = {10'd125, 6'd3, 3'd1};
      4'd11:   mps = {10'd100, 6'd3, 3'd1};
      4'd12:   mps = {10'd200, 6'd4, 3'd2};
      default: mps = {10'd100, 6'd3, 3'd2};
    endcase
  endfunction

  function automatic logic [31:0] div0_word(input logic [3:0] l);
    case (l)
      4'd0, 4'd1:               div0_word = 32'h0216_0730;
      4'd2, 4'd3:               div0_word = 32'h0215_0730;
      4'd4:                     div0_word = 32'h0214_0630;
      4'd5:                     div0_word = 32'h0114_0520;
      4'd6, 4'd7:               div0_word = 32'h0113_0520;
      4'd8, 4'd9, 4'd10, 4'd11: div0_word = 32'h0113_0420;
      4'd12:                    div0_word = 32'h0112_0420;
      default:                  div0_word = 32'h0111_0310;
    endcase
  endfunction

  function automatic logic [31:0] div1_word(input logic [3:0] l);
    logic [3:0] cp, cs;
    cp = (l < 4'd2) ? 4'd6 : (l < 4'd4) ? 4'd5 : (l < 4'd6) ? 4'd4 : 4'd3;
    cs = (4'd14 - l) >> 1;
    if (VARIANT != 0) div1_word = {20'd0, cs, 4'd0, cp};
    else              div1_word = {24'd0, 4'd2, cp};
  endfunction

  logic [18:0] tgt_mps, req_mps, cur_mps;
  assign tgt_mps = mps(tgt);
  assign req_mps = mps(req_level);
  assign cur_mps = mps(cur);

  wire accept  = req && (req_level < 4'(LEVELS));
  wire req_up  = req_level < cur;
  wire req_pll = req_mps[18:3] != cur_mps[18:3];

  always_comb begin
    is_wait = 1'b1;
    case (st)
      S_D0P:   wait_ok = (div0_stat & D0_MASK) == '0;
      S_D1P:   wait_ok = (div1_stat & D1_MASK) == '0;
      S_MAP:   wait_ok = mux_stat == 3'd2;
      S_PP:    wait_ok = pll_locked;
      S_MMP:   wait_ok = mux_stat == 3'd1;
      default: begin wait_ok = 1'b1; is_wait = 1'b0; end
    endcase
  end

  always_comb begin
    fin = 1'b0;
    nxt = S_IDLE;
    case (st)
      S_D0W: nxt = S_D0P;
      S_D0P: nxt = S_D1W;
      S_D1W: nxt = S_D1P;
      S_D1P: if (up) nxt = full ? S_MAW : S_SW; else fin = 1'b1;
      S_SW:  if (up) fin = 1'b1; else nxt = S_D0W;
      S_MAW: nxt = S_MAP;
      S_MAP: nxt = S_LKW;
      S_LKW: nxt = S_PW;
      S_PW:  nxt = S_PP;
      S_PP:  nxt = S_MMW;
      S_MMW: nxt = S_MMP;
      S_MMP: if (up) fin = 1'b1; else nxt = S_D0W;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      cur   <= SAFE;
      tgt   <= SAFE;
      up    <= 1'b0;
      full  <= 1'b0;
      tcnt  <= '0;
      ack_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      ack_q <= 1'b0;
      if (st == S_IDLE) begin
        tcnt <= '0;
        if (accept) begin
          if (req_level == cur) ack_q <= 1'b1;
          else begin
            tgt  <= req_level;
            up   <= req_up;
            full <= req_pll;
            st   <= req_up ? S_D0W : (req_pll ? S_MAW : S_SW);
          end
        end
      end else if (is_wait && !wait_ok) begin
        if (tcnt == tmo_limit) begin
          err_q <= 1'b1;
          st    <= S_IDLE;
        end else tcnt <= tcnt + 1'b1;
      end else begin
        tcnt <= '0;
        if (fin) begin
          st    <= S_IDLE;
          ack_q <= 1'b1;
          cur   <= tgt;
        end else st <= nxt;
      end
    end
  end

  assign busy       = st != S_IDLE;
  assign ack        = ack_q;
  assign err        = err_q;
  assign cur_level  = cur;
  assign safe_level = SAFE;
  assign div0_we    = st == S_D0W;
  assign div0_wd    = div0_word(tgt);
  assign div1_we    = st == S_D1W;
  assign div1_wd    = div1_word(tgt);
  assign mux_we     = (st == S_MAW) || (st == S_MMW);
  assign mux_to_alt = st == S_MAW;
  assign lock_we    = st == S_LKW;
  assign lock_wd    = 16'(tgt_mps[8:3]) * 16'd250;
  assign pll_we     = (st == S_SW) || (st == S_PW);
  assign pll_wd     = (st == S_SW) ? {pll_rd[31:3], tgt_mps[2:0]}
                    : (pll_rd & ~PLL_FIELDS) |
                      {6'd0, tgt_mps[18:9], 2'd0, tgt_mps[8:3], 5'd0, tgt_mps[2:0]};

  // R5
  lock_after_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_we |-> mux_stat == 3'd2);
  // R5
  main_after_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mux_we && !mux_to_alt) |-> pll_locked);
  // R7
  div1_after_div0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div1_we |-> (div0_stat & D0_MASK) == '0);
  // R9
  ack_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> !busy);
  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);
  // R11
  level_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_level != $past(cur_level)) |-> ack);
  // R1
  level_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cur_level < 4'(LEVELS));
endmodule

// File: tb/dvfs_seq_bench.sv
module dvfs_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DLY = 5;
  localparam logic [31:0] OTHER = 32'h8000_C0F8;
  localparam int M_T [14] = '{250,175,325,200,275,125,150,100,175,200,125,100,200,100};
  localparam int P_T [14] = '{4,3,6,4,6,3,4,3,3,4,3,3,4,3};
  localparam int S_T [14] = '{0,0,0,0,0,0,0,0,1,1,1,1,2,2};
  localparam logic [31:0] D0_T [14] = '{32'h02160730,32'h02160730,32'h02150730,32'h02150730,
    32'h02140630,32'h01140520,32'h01130520,32'h01130520,32'h01130420,32'h01130420,
    32'h01130420,32'h01130420,32'h01120420,32'h01110310};
  localparam logic [31:0] D1_T [14] = '{32'h26,32'h26,32'h25,32'h25,32'h24,32'h24,
    32'h23,32'h23,32'h23,32'h23,32'h23,32'h23,32'h23,32'h23};
  localparam int VEC [14] = '{3,9,12,0,13,11,11,1,8,5,10,2,4,7};

  logic clk = 1'b0, rst_n = 1'b0, req = 1'b0;
  logic [15:0] tmo_limit = 16'd100;
  logic [3:0]  req_level = 4'd0;
  logic busy, ack, err, div0_we, div1_we, pll_we, lock_we, mux_we, mux_to_alt;
  logic [3:0]  cur_level, safe_level;
  logic [31:0] div0_wd, div1_wd, pll_wd, div0_stat, div1_stat, pll_rd;
  logic [15:0] lock_wd;
  logic [2:0]  mux_stat, mux_tgt;
  logic        pll_locked;
  int d0c, d1c, mc, lc;
  int n_ev = 0, nchk = 0, nfail = 0, exp_cur = 7;
  int ev_c [512];
  logic [31:0] ev_d [512];

  always #(CLK_PERIOD/2) clk = ~clk;

  dvfs_seq u_dvfs_seq (
    .clk(clk), .rst_n(rst_n), .tmo_limit(tmo_limit), .req(req), .req_level(req_level),
    .busy(busy), .ack(ack), .err(err), .cur_level(cur_level), .safe_level(safe_level),
    .div0_we(div0_we), .div0_wd(div0_wd), .div0_stat(div0_stat),
    .div1_we(div1_we), .div1_wd(div1_wd), .div1_stat(div1_stat),
    .pll_we(pll_we), .pll_wd(pll_wd), .pll_rd(pll_rd), .pll_locked(pll_locked),
    .lock_we(lock_we), .lock_wd(lock_wd), .mux_we(mux_we), .mux_to_alt(mux_to_alt),
    .mux_stat(mux_stat));

  function automatic logic [31:0] pll_word(int l);
    return OTHER | (32'(M_T[l]) << 16) | (32'(P_T[l]) << 8) | 32'(S_T[l]);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      div0_stat <= '0; div1_stat <= '0; d0c <= 0; d1c <= 0;
      mux_stat <= 3'd1; mux_tgt <= 3'd1; mc <= 0;
      pll_locked <= 1'b1; lc <= 0; pll_rd <= pll_word(7);
    end else begin
      if (div0_we) begin div0_stat <= 32'h11111111; d0c <= DLY; end
      else if (d0c != 0) begin d0c <= d0c - 1; if (d0c == 1) div0_stat <= '0; end
      if (div1_we) begin div1_stat <= 32'h11; d1c <= DLY; end
      else if (d1c != 0) begin d1c <= d1c - 1; if (d1c == 1) div1_stat <= '0; end
      if (mux_we) begin mux_stat <= 3'd0; mux_tgt <= mux_to_alt ? 3'd2 : 3'd1; mc <= DLY; end
      else if (mc != 0) begin mc <= mc - 1; if (mc == 1) mux_stat <= mux_tgt; end
      if (pll_we) begin pll_rd <= pll_wd; pll_locked <= 1'b0; lc <= DLY; end
      else if (lc != 0) begin lc <= lc - 1; if (lc == 1) pll_locked <= 1'b1; end
    end
  end

  always @(posedge clk) begin
    if (rst_n) begin
      if (div0_we)      begin ev_c[n_ev % 512] <= 1; ev_d[n_ev % 512] <= div0_wd; n_ev <= n_ev + 1; end
      else if (div1_we) begin ev_c[n_ev % 512] <= 2; ev_d[n_ev % 512] <= div1_wd; n_ev <= n_ev + 1; end
      else if (mux_we)  begin ev_c[n_ev % 512] <= mux_to_alt ? 3 : 6; ev_d[n_ev % 512] <= 32'(mux_to_alt); n_ev <= n_ev + 1; end
      else if (lock_we) begin ev_c[n_ev % 512] <= 4; ev_d[n_ev % 512] <= 32'(lock_wd); n_ev <= n_ev + 1; end
      else if (pll_we)  begin ev_c[n_ev % 512] <= 5; ev_d[n_ev % 512] <= pll_wd; n_ev <= n_ev + 1; end
    end
  end

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  task automatic run_trans(int tgt, bit hold_other);
    int ec [8];
    logic [31:0] ed [8];
    string et [8];
    int ne = 0, start;
    bit up, full, got = 0;
    up = tgt < exp_cur;
    full = (M_T[tgt] != M_T[exp_cur]) || (P_T[tgt] != P_T[exp_cur]);
    if (tgt != exp_cur) begin
      for (int pass = 0; pass < 2; pass++) begin
        if ((pass == 0) == up) begin
          ec[ne] = 1; ed[ne] = D0_T[tgt]; et[ne] = "R7 div0 word"; ne++;
          ec[ne] = 2; ed[ne] = D1_T[tgt]; et[ne] = "R12 div1 word"; ne++;
        end else if (full) begin
          ec[ne] = 3; ed[ne] = 1; et[ne] = "R5 park"; ne++;
          ec[ne] = 4; ed[ne] = 32'(P_T[tgt] * 250); et[ne] = "R5 lock time"; ne++;
          ec[ne] = 5; ed[ne] = pll_word(tgt); et[ne] = "R6 pll word"; ne++;
          ec[ne] = 6; ed[ne] = 0; et[ne] = "R5 unpark"; ne++;
        end else begin
          ec[ne] = 5; ed[ne] = pll_word(tgt); et[ne] = "R4 s-only word"; ne++;
        end
      end
    end
    start = n_ev;
    @(negedge clk); req = 1'b1; req_level = 4'(tgt);
    @(negedge clk);
    if (hold_other) req_level = (tgt == 0) ? 4'd1 : 4'd0; else req = 1'b0;
    if (tgt != exp_cur) chk(busy == 1'b1, "R9 busy after accept", 32'(busy), 1);
    for (int i = 0; i < 3000 && !got; i++) begin
      if (ack) got = 1; else @(negedge clk);
    end
    req = 1'b0;
    chk(got, "R9 ack seen", 32'(got), 1);
    chk(busy == 1'b0, "R9 idle at ack", 32'(busy), 0);
    @(negedge clk);
    chk(ack == 1'b0, "R9 ack single pulse", 32'(ack), 0);
    if (hold_other) begin
      repeat (20) @(negedge clk);
      chk(busy == 1'b0, "R9 request during busy ignored", 32'(busy), 0);
    end
    chk(n_ev - start == ne, tgt == exp_cur ? "R8 write count" : (full ? "R5 write count" : "R4 write count"),
        32'(n_ev - start), 32'(ne));
    for (int i = 0; i < ne && i < n_ev - start; i++) begin
      chk(ev_c[(start + i) % 512] == ec[i], up ? "R2 step order" : "R3 step order",
          32'(ev_c[(start + i) % 512]), 32'(ec[i]));
      chk(ev_d[(start + i) % 512] == ed[i], et[i], ev_d[(start + i) % 512], ed[i]);
    end
    chk(cur_level == 4'(tgt), "R11 level after ack", 32'(cur_level), 32'(tgt));
    exp_cur = tgt;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    int start;
    bit saw_ack;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cur_level == 4'd7, "R1 reset level", 32'(cur_level), 7);
    chk(safe_level == 4'd7, "R1 safe level", 32'(safe_level), 7);
    chk({busy, ack, err} == 3'b000, "R9 reset outputs", 32'({busy, ack, err}), 0);

    foreach (VEC[k]) run_trans(VEC[k], 1'b0);

    start = n_ev; saw_ack = 0;
    for (int l = 14; l < 16; l++) begin
      @(negedge clk); req = 1'b1; req_level = 4'(l);
      @(negedge clk); req = 1'b0;
      repeat (8) begin if (ack || busy) saw_ack = 1; @(negedge clk); end
    end
    chk(!saw_ack && n_ev == start, "R9 out-of-range ignored", 32'(n_ev - start), 0);
    chk(cur_level == 4'(exp_cur), "R9 out-of-range level", 32'(cur_level), 32'(exp_cur));

    run_trans(3, 1'b1);

    tmo_limit = 16'(DLY);
    run_trans(9, 1'b0);
    chk(err == 1'b0, "R10 condition wins at limit", 32'(err), 0);

    tmo_limit = 16'(DLY - 1);
    start = n_ev; saw_ack = 0;
    @(negedge clk); req = 1'b1; req_level = 4'd0;
    @(negedge clk); req = 1'b0;
    for (int i = 0; i < 200 && busy; i++) begin if (ack) saw_ack = 1; @(negedge clk); end
    if (ack) saw_ack = 1;
    chk(err == 1'b1, "R10 timeout flag", 32'(err), 1);
    chk(!saw_ack, "R10 no ack on timeout", 32'(saw_ack), 0);
    chk(cur_level == 4'd9, "R10 level kept", 32'(cur_level), 9);
    chk(n_ev - start == 1, "R10 abandoned after div0", 32'(n_ev - start), 1);
    tmo_limit = 16'd100;
    repeat (10) @(negedge clk);
    run_trans(9, 1'b0);
    chk(err == 1'b1, "R10 flag sticky", 32'(err), 1);

    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule